// File: doc/BRIEF.md
# SPI Flash Command Master

This block runs one serial-flash transaction at a time on a four-wire SPI bus, using clock mode 0 only. A host hands it a command word. The command carries an opcode, a 24-bit address and a flag that says whether the address is sent. It also carries a direction, a data byte count and, for writes, up to four data bytes packed into one word. The engine pulls chip select low and shifts out the opcode. It then shifts out the address, if the command has one, and after that either sends the write bytes or collects read bytes. Chip select rises again together with the last falling clock edge of the frame, so every frame is a whole number of bytes.

Opcode and address bits go out most significant bit first. Data bursts run least significant byte first, and each byte is still sent most significant bit first. Read bytes are packed the same way: the first byte received lands in bits 7:0 of the returned word. Two rules apply to the read-result channel. Once `rd_valid` is high, it holds with a stable `rd_data` until `rd_ready` takes the word. While a result is pending, or while a frame is running, `cmd_ready` stays low. Commands that need no address are issued with `cmd_has_addr` low, for example write disable (0x04) and read status (0x05).

Top module: `spi_flash_cmd_master`

## Requirements
- R1: `spi_sclk` is low whenever `spi_cs_n` is high, and while `spi_cs_n` is low `spi_mosi` changes only on a falling `spi_sclk` edge (mode 0).
- R2: Successive rising `spi_sclk` edges within a frame are exactly `CLK_DIV` system cycles apart.
- R3: An accepted command drops `spi_cs_n` on the next clock edge, and the first 8 bits on MOSI are the opcode, bit 7 first.
- R4: With `cmd_has_addr` high, the 24 address bits follow the opcode, bit 23 first and bit 0 last.
- R5: In a write, data byte k is `cmd_wdata[8k+7:8k]`, sent in the order k = 0, 1, ..., and each byte is sent bit 7 first.
- R6: In a read, MISO is sampled on rising `spi_sclk` edges only after the header. Byte k received goes to `rd_data[8k+7:8k]`, most significant bit first. Unused upper bytes read as zero, and MOSI is held low during the read data bytes.
- R7: A frame carries exactly 8*(1 + 3*has_addr + count) clock pulses, and `spi_cs_n` rises only after a multiple of 8 pulses.
- R8: A command with no address and a count of 0 is an 8-bit opcode-only frame. A command with no address and a nonzero count goes straight from the opcode to the data bytes.
- R9: `busy` is high from the fall of `spi_cs_n` until one SCLK half-period (`CLK_DIV`/2 cycles) after `spi_cs_n` rises. At that point `done` pulses for one cycle as `busy` falls.
- R10: `cmd_ready` is low while `busy` or `rd_valid` is high, and a command offered then starts no frame.
- R11: `rd_valid` rises with `done` only for reads with a nonzero count. It then holds, with `rd_data` stable, until a cycle with `rd_ready` high.
- R12: A byte count above `MAX_BYTES` is treated as `MAX_BYTES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and no read result pending |
| cmd_opcode | input | 8 | Instruction byte |
| cmd_addr | input | 8*ADDR_BYTES | Target address |
| cmd_has_addr | input | 1 | Send the address phase |
| cmd_write | input | 1 | 1 = send data bytes, 0 = read data bytes |
| cmd_nbytes | input | clog2(MAX_BYTES+1) | Data byte count |
| cmd_wdata | input | 8*MAX_BYTES | Write bytes, byte 0 in the low bits |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Host takes the read word |
| rd_data | output | 8*MAX_BYTES | Read bytes, first byte in the low bits |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the target |
| spi_miso | input | 1 | Serial data from the target |

## Verification
The bench builds the block with `CLK_DIV` = 4, so each SCLK half-period spans two system cycles. An off-by-one in the half-period timer or in the chip-select-to-`done` gap therefore shows up as a wrong cycle count. `MAX_BYTES` = 4 and `ADDR_BYTES` = 3 make the longest frame, eight bytes, reachable. They also let an out-of-range count of 7 test the clamp, and let a one-byte read after a four-byte read show that stale upper bytes are cleared.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/spi_half_timer.sv
// Emits a tick every HALF cycles while run is high; restarts at zero when run drops.
module spi_half_timer #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (tick)     cnt_q <= '0;
    else               cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/spi_tx_byte_sel.sv
// Picks the byte for a frame position: opcode, address high to low, then data low byte first.
module spi_tx_byte_sel #(
  parameter int ADDR_BYTES = 3,
  parameter int MAX_BYTES  = 4,
  parameter int POS_W      = 4
) (
  input  logic [POS_W-1:0]          pos,
  input  logic [POS_W-1:0]          hdr,
  input  logic [7:0]                opcode,
  input  logic [8*ADDR_BYTES-1:0]   addr,
  input  logic                      has_addr,
  input  logic                      write,
  input  logic [8*MAX_BYTES-1:0]    wdata,
  output logic [7:0]                byte_out
);
  localparam int ADDR_W = 8 * ADDR_BYTES;

  always_comb begin
    byte_out = 8'h00;
    if (pos == '0) byte_out = opcode;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (has_addr && (pos == POS_W'(i + 1)))
        byte_out = addr[ADDR_W-8-8*i +: 8];
    end
    for (int j = 0; j < MAX_BYTES; j++) begin
      if (write && (pos == hdr + POS_W'(j)))
        byte_out = wdata[8*j +: 8];
    end
  end
endmodule

// File: rtl/spi_rx_packer.sv
// Shifts sampled bits into the byte slot selected by slot, MSB first.
module spi_rx_packer #(
  parameter int MAX_BYTES = 4,
  parameter int POS_W     = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     sample,
  input  logic                     bit_in,
  input  logic [POS_W-1:0]         slot,
  output logic [8*MAX_BYTES-1:0]   word
);
  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q <= 8'h00;
      else if (clear)
        slot_q <= 8'h00;
      else if (sample && (slot == POS_W'(k)))
        slot_q <= {slot_q[6:0], bit_in};
    end
    assign word[8*k +: 8] = slot_q;
  end
endmodule

// File: rtl/spi_flash_cmd_master.sv
module spi_flash_cmd_master
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int ADDR_BYTES = 3,
  parameter int MAX_BYTES  = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cmd_valid,
  output logic                              cmd_ready,
  input  logic [7:0]                        cmd_opcode,
  input  logic [8*ADDR_BYTES-1:0]           cmd_addr,
  input  logic                              cmd_has_addr,
  input  logic                              cmd_write,
  input  logic [$clog2(MAX_BYTES+1)-1:0]    cmd_nbytes,
  input  logic [8*MAX_BYTES-1:0]            cmd_wdata,
  output logic                              rd_valid,
  input  logic                              rd_ready,
  output logic [8*MAX_BYTES-1:0]            rd_data,
  output logic                              busy,
  output logic                              done,
  output logic                              spi_sclk,
  output logic                              spi_cs_n,
  output logic                              spi_mosi,
  input  logic                              spi_miso
);
  localparam int HALF   = CLK_DIV / 2;
  localparam int NB_W   = $clog2(MAX_BYTES + 1);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int DATA_W = 8 * MAX_BYTES;
  localparam int POS_W  = $clog2(ADDR_BYTES + MAX_BYTES + 2);

  seq_state_e           state_q;
  logic [7:0]           op_q;
  logic [ADDR_W-1:0]    addr_q;
  logic                 has_addr_q;
  logic                 write_q;
  logic [DATA_W-1:0]    wdata_q;
  logic [POS_W-1:0]     hdr_q, total_q, pos_q;
  logic [2:0]           bit_q;
  logic                 sclk_q, cs_n_q, busy_q, done_q, rd_valid_q;
  logic [7:0]           tx_q;

  logic                 fire, tick, rx_sample;
  logic [NB_W-1:0]      nb_clamp;
  logic [POS_W-1:0]     hdr_in, total_in, pos_next;
  logic [7:0]           next_byte;

  assign cmd_ready = (state_q == ST_IDLE) && !rd_valid_q;
  assign fire      = cmd_valid && cmd_ready;

  // Counts above the word capacity are clamped (R12).
  assign nb_clamp = (cmd_nbytes > NB_W'(MAX_BYTES)) ? NB_W'(MAX_BYTES) : cmd_nbytes;
  assign hdr_in   = cmd_has_addr ? POS_W'(1 + ADDR_BYTES) : POS_W'(1);
  assign total_in = hdr_in + POS_W'(nb_clamp);
  assign pos_next = pos_q + POS_W'(1);

  spi_half_timer #(.HALF(HALF)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q != ST_IDLE),
    .tick  (tick)
  );

  spi_tx_byte_sel #(
    .ADDR_BYTES (ADDR_BYTES),
    .MAX_BYTES  (MAX_BYTES),
    .POS_W      (POS_W)
  ) u_sel (
    .pos      (pos_next),
    .hdr      (hdr_q),
    .opcode   (op_q),
    .addr     (addr_q),
    .has_addr (has_addr_q),
    .write    (write_q),
    .wdata    (wdata_q),
    .byte_out (next_byte)
  );

  // Read bits are taken on the rising SCLK edge once the header is over.
  assign rx_sample = tick && !sclk_q && (state_q == ST_SHIFT) && !write_q && (pos_q >= hdr_q);

  spi_rx_packer #(
    .MAX_BYTES (MAX_BYTES),
    .POS_W     (POS_W)
  ) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (fire),
    .sample (rx_sample),
    .bit_in (spi_miso),
    .slot   (pos_q - hdr_q),
    .word   (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      op_q       <= 8'h00;
      addr_q     <= '0;
      has_addr_q <= 1'b0;
      write_q    <= 1'b0;
      wdata_q    <= '0;
      hdr_q      <= '0;
      total_q    <= '0;
      pos_q      <= '0;
      bit_q      <= 3'd0;
      sclk_q     <= 1'b0;
      cs_n_q     <= 1'b1;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      tx_q       <= 8'h00;
    end else begin
      done_q <= 1'b0;
      if (rd_valid_q && rd_ready) rd_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (fire) begin
            op_q       <= cmd_opcode;
            addr_q     <= cmd_addr;
            has_addr_q <= cmd_has_addr;
            write_q    <= cmd_write;
            wdata_q    <= cmd_wdata;
            hdr_q      <= hdr_in;
            total_q    <= total_in;
            pos_q      <= '0;
            bit_q      <= 3'd0;
            sclk_q     <= 1'b0;
            cs_n_q     <= 1'b0;
            busy_q     <= 1'b1;
            tx_q       <= cmd_opcode;
            state_q    <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
            end else begin
              sclk_q <= 1'b0;
              if (bit_q != 3'd7) begin
                bit_q <= bit_q + 3'd1;
                tx_q  <= {tx_q[6:0], 1'b0};
              end else if (pos_next == total_q) begin
                // Last bit of the last byte: release select on this falling edge.
                cs_n_q  <= 1'b1;
                tx_q    <= 8'h00;
                state_q <= ST_GAP;
              end else begin
                bit_q <= 3'd0;
                pos_q <= pos_next;
                tx_q  <= next_byte;
              end
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            busy_q     <= 1'b0;
            done_q     <= 1'b1;
            rd_valid_q <= !write_q && (total_q != hdr_q);
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign spi_sclk = sclk_q;
  assign spi_cs_n = cs_n_q;
  assign spi_mosi = tx_q[7];
  assign busy     = busy_q;
  assign done     = done_q;
  assign rd_valid = rd_valid_q;
endmodule

// File: rtl/spi_flash_cmd_checker.sv
module spi_flash_cmd_checker #(
  parameter int CLK_DIV = 4,
  parameter int DATA_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_cs_n,
  input logic              spi_sclk,
  input logic              spi_mosi,
  input logic              busy,
  input logic              done,
  input logic              cmd_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data
);
  logic        sclk_d, cs_d, seen_q;
  logic [15:0] gap_q;
  logic [7:0]  pulses_q;
  logic        rise;

  assign rise = spi_sclk && !sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      cs_d     <= 1'b1;
      seen_q   <= 1'b0;
      gap_q    <= '0;
      pulses_q <= '0;
    end else begin
      sclk_d <= spi_sclk;
      cs_d   <= spi_cs_n;
      if (spi_cs_n)       seen_q <= 1'b0;
      else if (rise)      seen_q <= 1'b1;
      if (rise)                  gap_q <= 16'd1;
      else if (gap_q != '1)      gap_q <= gap_q + 16'd1;
      if (!spi_cs_n && cs_d)     pulses_q <= '0;
      else if (rise)             pulses_q <= pulses_q + 8'd1;
    end
  end

  // R1: clock idles low outside a frame
  p_sclk_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R1: MOSI only moves on a falling SCLK edge inside a frame
  p_mosi_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && !$past(spi_cs_n) && !$fell(spi_sclk)) |-> $stable(spi_mosi));

  // R2: rising edges spaced by the divider
  p_sclk_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && seen_q && !spi_cs_n) |-> (gap_q == 16'(CLK_DIV)));

  // R7: select released only on a byte boundary
  p_cs_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> ((pulses_q[2:0] == 3'd0) && (pulses_q != 8'd0)));

  // R9: busy covers the whole frame, done is a single cycle after busy
  p_busy_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && spi_cs_n) ##1 !done);

  // R10: no command acceptance while busy or a result is pending
  p_ready_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!busy && !rd_valid));

  // R11: result holds under back-pressure
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

bind spi_flash_cmd_master spi_flash_cmd_checker #(
  .CLK_DIV (CLK_DIV),
  .DATA_W  (8 * MAX_BYTES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .spi_cs_n  (spi_cs_n),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .busy      (busy),
  .done      (done),
  .cmd_ready (cmd_ready),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data)
);

// File: tb/tb_spi_flash_cmd_master.sv
module tb_spi_flash_cmd_master;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_opcode = 8'h00;
  logic [23:0] cmd_addr = 24'h0;
  logic        cmd_has_addr = 1'b0;
  logic        cmd_write = 1'b0;
  logic [2:0]  cmd_nbytes = 3'd0;
  logic [31:0] cmd_wdata = 32'h0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [31:0] rd_data;
  logic        busy, done, spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  always #5 clk = ~clk;

  spi_flash_cmd_master #(.CLK_DIV(DIV), .ADDR_BYTES(3), .MAX_BYTES(4)) dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
    .cmd_addr(cmd_addr), .cmd_has_addr(cmd_has_addr), .cmd_write(cmd_write),
    .cmd_nbytes(cmd_nbytes), .cmd_wdata(cmd_wdata),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy(busy), .done(done),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Target model: records MOSI on rising SCLK, presents MISO after falling SCLK.
  int          cyc = 0;
  int          last_rise = 0;
  int          nbits = 0;
  int          midx = 0;
  int          per_err = 0;
  logic [63:0] cap = '0;
  logic [63:0] resp = '0;

  always @(posedge clk) cyc = cyc + 1;

  always @(negedge spi_cs_n) begin
    nbits = 0; cap = '0; midx = 0; spi_miso = resp[63];
  end

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    cap = {cap[62:0], spi_mosi};
    if (nbits > 0 && (cyc - last_rise) != DIV) per_err++;
    last_rise = cyc;
    nbits++;
  end

  always @(negedge spi_sclk) if (!spi_cs_n) begin
    midx++;
    if (midx < 64) spi_miso = resp[63 - midx];
  end

  task automatic run_cmd(input logic [7:0] op, input logic [23:0] ad, input bit ha,
                         input bit wr, input logic [2:0] nb, input logic [31:0] wd,
                         input logic [31:0] rb, input bit keep_rd, input string tag);
    int n, hdr, total, guard, lat;
    bit busy_ok, ready_nok;
    logic [63:0] expv;
    logic [31:0] exp_rd, tmp;
    logic [23:0] at;
    logic [7:0]  b, r;
    n = (nb > 3'd4) ? 4 : int'(nb);
    hdr = ha ? 4 : 1;
    total = hdr + n;
    expv = '0; exp_rd = '0; resp = '0;
    for (int i = 0; i < total; i++) begin
      r = 8'hA5;
      if (i == 0) b = op;
      else if (i < hdr) begin at = ad >> (8 * (3 - i)); b = at[7:0]; end
      else begin
        tmp = wd >> (8 * (i - hdr)); b = wr ? tmp[7:0] : 8'h00;
        tmp = rb >> (8 * (i - hdr)); r = tmp[7:0];
        exp_rd[8*(i-hdr) +: 8] = r;
      end
      expv = {expv[55:0], b};
      resp[63 - 8*i -: 8] = r;
    end
    per_err = 0;
    @(negedge clk);
    cmd_opcode = op; cmd_addr = ad; cmd_has_addr = ha; cmd_write = wr;
    cmd_nbytes = nb; cmd_wdata = wd; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(spi_cs_n == 1'b0, {tag, " R3 select falls after accept"}, 64'(spi_cs_n), 64'd0);
    guard = 0; busy_ok = 1'b1; ready_nok = 1'b0;
    while (spi_cs_n == 1'b0 && guard < 2000) begin
      if (!busy) busy_ok = 1'b0;
      if (cmd_ready) ready_nok = 1'b1;
      @(negedge clk);
      guard++;
    end
    lat = 0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    check(lat == DIV/2, {tag, " R9 select-rise to done gap"}, 64'(lat), 64'(DIV/2));
    check(busy_ok && !busy, {tag, " R9 busy covers frame, drops with done"}, 64'(busy), 64'd0);
    check(!ready_nok, {tag, " R10 ready low while busy"}, 64'(ready_nok), 64'd0);
    check(nbits == 8*total, {tag, " R7 pulse count"}, 64'(nbits), 64'(8*total));
    check(cap == expv, {tag, " R3 R4 R5 R6 MOSI bit stream"}, cap, expv);
    check(per_err == 0, {tag, " R2 SCLK period"}, 64'(per_err), 64'd0);
    if (!wr && n > 0) begin
      check(rd_valid && rd_data == exp_rd, {tag, " R6 R12 read word"}, 64'(rd_data), 64'(exp_rd));
      if (!keep_rd) begin
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
        check(!rd_valid && cmd_ready, {tag, " R11 result taken"}, 64'(rd_valid), 64'd0);
      end
    end else begin
      check(!rd_valid, {tag, " R11 no result for this command"}, 64'(rd_valid), 64'd0);
    end
  endtask

  task automatic t_reset();
    check(spi_cs_n && !spi_sclk && !busy && !done && !rd_valid && cmd_ready,
          "R1 R10 reset state", {58'd0, spi_cs_n, spi_sclk, busy, done, rd_valid, cmd_ready},
          64'b100001);
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    int starts;
    run_cmd(8'h03, 24'h00_10_20, 1'b1, 1'b0, 3'd2, 32'h0, 32'h0000_C3B2, 1'b1, "held read");
    held = rd_data;
    starts = 0;
    cmd_opcode = 8'h04; cmd_has_addr = 1'b0; cmd_nbytes = 3'd0; cmd_valid = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!spi_cs_n || cmd_ready) starts++;
    end
    check(starts == 0, "R10 command refused while result pending", 64'(starts), 64'd0);
    check(rd_valid && rd_data == held && held == 32'h0000_C3B2, "R11 result held under back-pressure",
          64'(rd_data), 64'h0000_C3B2);
    cmd_valid = 1'b0; rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    check(!rd_valid && cmd_ready && spi_cs_n, "R11 result released", 64'(rd_valid), 64'd0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    // R8: opcode-only frame (write disable)
    run_cmd(8'h04, 24'hFFFFFF, 1'b0, 1'b1, 3'd0, 32'hFFFF_FFFF, 32'h0, 1'b0, "opcode only R8");
    // R4 R5: program three bytes at an address
    run_cmd(8'h02, 24'h12_34_56, 1'b1, 1'b1, 3'd3, 32'h00CC_BBAA, 32'h0, 1'b0, "program R5");
    // R6: four-byte read with address
    run_cmd(8'h03, 24'hAB_CD_EF, 1'b1, 1'b0, 3'd4, 32'h0, 32'hEFBE_ADDE, 1'b0, "read R6");
    // R8 R6: status read, one byte, no address; upper bytes must clear
    run_cmd(8'h05, 24'h0, 1'b0, 1'b0, 3'd1, 32'h0, 32'h9988_775A, 1'b0, "status R8");
    // R5 R8: status write, one byte, no address
    run_cmd(8'h01, 24'h0, 1'b0, 1'b1, 3'd1, 32'h0000_003C, 32'h0, 1'b0, "status write R8");
    // R12: count 7 behaves as 4
    run_cmd(8'h03, 24'h00_00_01, 1'b1, 1'b0, 3'd7, 32'h0, 32'h4433_2211, 1'b0, "clamp R12");
    t_backpressure();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule